// File: doc/BRIEF.md
# Host-Clocked Serial Result Reader

This controller sits on the host side of an 18-bit successive-approximation converter whose serial port runs as a clock follower. The host makes the serial clock here. The controller issues a one-cycle conversion strobe and follows the converter's busy line. It then pulls chip-select and read-enable low for one frame and drives a burst of clock pulses that stops between frames. While it clocks, it shifts in the result with the most significant bit first. The assembled word leaves with a single-cycle valid strobe.

Two scheduling policies are available. In read-after mode, a frame begins once busy drops and fetches the result just produced. In read-during mode, the controller fetches the previous result while the next conversion runs. It does this only when the whole frame ends before half the nominal conversion length has passed. Otherwise it waits for busy to drop, so no clock edge lands in the sensitive second half of a conversion. The clock's idle level and its half-period, in system cycles, are set by inputs.

Top module: `slv_rd_host`

## Requirements
- R1: While reset is asserted, `cs_n` and `rd_n` are 1, `sclk` equals `idle_hi`, and `cnv_start` and `word_vld` are 0.
- R2: `cnv_start` is a one-cycle pulse. It is raised only while `go` is 1, `busy` is low and no frame is open. It is never raised while `go` stays 0.
- R3: `sclk` changes level only while `cs_n` and `rd_n` are both 0, and both were already 0 in the previous cycle.
- R4: Each frame has exactly 18 clock pulses. The first bit read is bit 17 of the result, so `word_out` equals the converter's result.
- R5: A pulse leaves the idle level `idle_hi` and then returns to it. The host samples `sdata` as the clock leaves idle, the converter moves to its next bit as the clock returns, and `sclk` rests at `idle_hi` between frames.
- R6: When `rd_during` is 0, a frame starts after `busy` falls and reads the result of the conversion that just ended. `word_vld` then rises while `busy` is low.
- R7: When `rd_during` is 1 and the frame fits (2·18·half-period + 2 ≤ CONV_CYC/2), the conversion whose result has not been read yet is read while the next conversion is busy. `word_vld` rises while `busy` is still high.
- R8: When `rd_during` is 1 and the frame does not fit, the read is postponed until `busy` falls. It then reads the just-finished result, and `word_vld` rises while `busy` is low.
- R9: `word_vld` lasts one cycle. In that cycle `cs_n` and `rd_n` are already back at 1.
- R10: Each clock phase, from chip-select falling to the first edge and between successive edges, lasts `half_per` system cycles. A `half_per` of 0 acts as 1.
- R11: No `sclk` edge occurs once `busy` has been high for CONV_CYC/2 cycles or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Permission to launch conversions |
| rd_during | input | 1 | 1 = read during the following conversion, 0 = read after each conversion |
| idle_hi | input | 1 | Idle level of the serial clock; hold static out of reset |
| half_per | input | HP_W | Serial clock half-period in system cycles (0 acts as 1) |
| busy | input | 1 | Converter busy line |
| sdata | input | 1 | Serial data from the converter |
| cnv_start | output | 1 | Conversion start strobe |
| cs_n | output | 1 | Chip-select, active low |
| rd_n | output | 1 | Read-enable, active low |
| sclk | output | 1 | Serial clock supplied to the converter |
| word_out | output | WORD_W | Assembled result |
| word_vld | output | 1 | One-cycle strobe marking `word_out` as new |

## Verification
The hardest case to reach is the read-during frame, which must fit inside the first half of busy. No read happens while the first conversion runs, so the bench has to run a full conversion to leave a result pending before any read-during frame can occur. The bench gets there by holding `go` high for several conversions in a row with a one-cycle half-period. It checks that every word matches the previous conversion's value and arrives while busy is high. A second run uses a two-cycle half-period, which no longer fits, and shows that the read moves past the falling edge of busy. A behavioural converter in the bench counts every clock edge that lands in the late half of busy, and every edge made while the port is deselected.

// File: rtl/slv_rd_pkg.sv
package slv_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_BUSYW,
        ST_READ,
        ST_DONE
    } rd_state_e;

endpackage

// File: rtl/slv_sclk_engine.sv
module slv_sclk_engine #(
    parameter int W    = 18,
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            idle_hi,
    input  logic [HP_W-1:0] half_per,
    output logic            sclk,
    output logic            lead,
    output logic            last
);
    localparam int PC_W = $clog2(W + 1);

    typedef struct packed {
        logic [HP_W-1:0] cnt;
        logic            phase;
        logic [PC_W-1:0] npulse;
    } eng_t;

    eng_t            eng_q, eng_d;
    logic [HP_W-1:0] hp_eff;

    assign hp_eff = (half_per == '0) ? HP_W'(1) : half_per;
    assign sclk   = eng_q.phase ^ idle_hi;

    always_comb begin
        eng_d = eng_q;
        lead  = 1'b0;
        last  = 1'b0;
        if (!run) begin
            eng_d = '0;
        end else if (eng_q.cnt >= hp_eff - HP_W'(1)) begin
            eng_d.cnt   = '0;
            eng_d.phase = ~eng_q.phase;
            if (!eng_q.phase) begin
                lead = 1'b1;
            end else if (eng_q.npulse == PC_W'(W - 1)) begin
                last         = 1'b1;
                eng_d.npulse = '0;
            end else begin
                eng_d.npulse = eng_q.npulse + PC_W'(1);
            end
        end else begin
            eng_d.cnt = eng_q.cnt + HP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> eng_q.cnt < hp_eff); // R10
    AST_PULSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.npulse < PC_W'(W)); // R4
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk == idle_hi); // R5

endmodule

// File: rtl/slv_rx_shift.sv
module slv_rx_shift #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    logic [W-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = sh_q;
        if (en) sh_d = {sh_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign word = sh_q;

endmodule

// File: rtl/slv_rd_host.sv
module slv_rd_host
    import slv_rd_pkg::*;
#(
    parameter int WORD_W   = 18,
    parameter int HP_W     = 8,
    parameter int CONV_CYC = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              rd_during,
    input  logic              idle_hi,
    input  logic [HP_W-1:0]   half_per,
    input  logic              busy,
    input  logic              sdata,
    output logic              cnv_start,
    output logic              cs_n,
    output logic              rd_n,
    output logic              sclk,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);
    localparam int HALF_CYC = CONV_CYC / 2;
    localparam int BZ_W     = $clog2(CONV_CYC + 2);

    typedef struct packed {
        rd_state_e         st;
        logic              cnv;
        logic              csn;
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              pend;
        logic              mid;
    } host_t;

    host_t             h_q, h_d;
    logic              lead, last, run;
    logic [WORD_W-1:0] sh_word;
    logic [HP_W-1:0]   hp_eff;
    logic [31:0]       frame_len;
    logic              fits;

    assign hp_eff    = (half_per == '0) ? HP_W'(1) : half_per;
    assign frame_len = 32'(2 * WORD_W) * 32'(hp_eff);
    assign fits      = (frame_len + 32'd2) <= 32'(HALF_CYC);
    assign run       = (h_q.st == ST_READ);

    slv_sclk_engine #(.W(WORD_W), .HP_W(HP_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .idle_hi  (idle_hi),
        .half_per (half_per),
        .sclk     (sclk),
        .lead     (lead),
        .last     (last)
    );

    slv_rx_shift #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (lead),
        .din   (sdata),
        .word  (sh_word)
    );

    always_comb begin
        h_d     = h_q;
        h_d.cnv = 1'b0;
        h_d.vld = 1'b0;
        unique case (h_q.st)
            ST_IDLE: begin
                if (go && !busy) begin
                    h_d.cnv = 1'b1;
                    h_d.st  = ST_ARM;
                end
            end
            ST_ARM: begin
                if (busy) begin
                    if (rd_during && fits && h_q.pend) begin
                        h_d.st   = ST_READ;
                        h_d.csn  = 1'b0;
                        h_d.mid  = 1'b1;
                        h_d.pend = 1'b0;
                    end else begin
                        h_d.st = ST_BUSYW;
                    end
                end
            end
            ST_BUSYW: begin
                if (!busy) begin
                    h_d.mid = 1'b0;
                    if (rd_during && fits) begin
                        h_d.pend = 1'b1;
                        h_d.st   = ST_IDLE;
                    end else begin
                        h_d.st  = ST_READ;
                        h_d.csn = 1'b0;
                    end
                end
            end
            ST_READ: begin
                if (last) h_d.st = ST_DONE;
            end
            ST_DONE: begin
                h_d.csn  = 1'b1;
                h_d.vld  = 1'b1;
                h_d.word = sh_word;
                h_d.st   = h_q.mid ? ST_BUSYW : ST_IDLE;
            end
            default: h_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q     <= '0;
            h_q.st  <= ST_IDLE;
            h_q.csn <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    assign cnv_start = h_q.cnv;
    assign cs_n      = h_q.csn;
    assign rd_n      = h_q.csn;
    assign word_out  = h_q.word;
    assign word_vld  = h_q.vld;

    // cycles busy has been high, kept for the late-edge check
    logic [BZ_W-1:0] bz_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        bz_q <= '0;
        else if (!busy)                    bz_q <= '0;
        else if (bz_q != BZ_W'(CONV_CYC + 1)) bz_q <= bz_q + BZ_W'(1);
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |=> !cnv_start); // R2
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_start |-> (!busy && cs_n)); // R2
    AST_GATED_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> (!cs_n && !rd_n && !$past(cs_n) && !$past(rd_n))); // R3
    AST_NO_LATE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> !($past(busy) && ($past(bz_q) >= BZ_W'(HALF_CYC)))); // R11
    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R9
    AST_VLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (cs_n && rd_n)); // R9

endmodule

// File: tb/sim_slv_rd_host.sv
`timescale 1ns/1ps
module sim_slv_rd_host;
    localparam int W    = 18;
    localparam int HP_W = 8;
    localparam int CONV = 128;
    localparam int HALF = CONV / 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            go = 1'b0;
    logic            rd_during = 1'b0;
    logic            idle_hi = 1'b0;
    logic [HP_W-1:0] half_per = HP_W'(1);
    logic            busy;
    logic            sdata;
    logic            cnv_start, cs_n, rd_n, sclk, word_vld;
    logic [W-1:0]    word_out;

    always #10 clk = ~clk;

    slv_rd_host #(.WORD_W(W), .HP_W(HP_W), .CONV_CYC(CONV)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .rd_during(rd_during),
        .idle_hi(idle_hi), .half_per(half_per), .busy(busy), .sdata(sdata),
        .cnv_start(cnv_start), .cs_n(cs_n), .rd_n(rd_n), .sclk(sclk),
        .word_out(word_out), .word_vld(word_vld)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    function automatic logic [W-1:0] cval(int k);
        return W'((k + 1) * 32'h0001D3B7 ^ (k * 32'h000002A5));
    endfunction

    // behavioural converter
    logic [W-1:0] out_reg;
    logic [W-1:0] hist [0:63];
    logic [W-1:0] wbuf [0:63];
    logic         wbusy [0:63];
    int nconv, bcnt, nstart, bad_start, nw;
    int late_viol, gate_viol, idx, npul, nfr, fr_bad;
    int minw, maxw, last_evt, vld2, vcs_bad;
    logic last_sclk, prev_sclk, prev_csn, prev_vld;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            busy <= 1'b0; out_reg <= '0; nconv <= 0; bcnt <= 0; nstart <= 0;
            bad_start <= 0; nw <= 0; nfr <= 0; fr_bad <= 0; minw <= 1000;
            maxw <= 0; last_evt <= 0; vld2 <= 0; vcs_bad <= 0;
            prev_sclk <= sclk; prev_csn <= 1'b1; prev_vld <= 1'b0;
        end else begin
            if (cnv_start) begin
                nstart <= nstart + 1;
                if (busy || !cs_n) bad_start <= bad_start + 1;
            end
            if (busy) begin
                bcnt <= bcnt + 1;
                if (bcnt == CONV - 1) begin
                    busy <= 1'b0;
                    out_reg <= cval(nconv);
                    if (nconv < 64) hist[nconv] <= cval(nconv);
                    nconv <= nconv + 1;
                end
            end else begin
                bcnt <= 0;
                if (cnv_start) busy <= 1'b1;
            end
            if (word_vld && nw < 64) begin
                wbuf[nw] <= word_out; wbusy[nw] <= busy; nw <= nw + 1;
            end
            if (word_vld && prev_vld) vld2 <= vld2 + 1;
            if (word_vld && (!cs_n || !rd_n)) vcs_bad <= vcs_bad + 1;
            if (prev_csn && !cs_n) last_evt <= cyc;
            else if (sclk != prev_sclk && !cs_n) begin
                if (cyc - last_evt < minw) minw <= cyc - last_evt;
                if (cyc - last_evt > maxw) maxw <= cyc - last_evt;
                last_evt <= cyc;
            end
            if (!prev_csn && cs_n) begin
                nfr <= nfr + 1;
                if (npul != W) fr_bad <= fr_bad + 1;
            end
            prev_sclk <= sclk; prev_csn <= cs_n; prev_vld <= word_vld;
        end
    end

    always @(sclk, cs_n, rd_n, rst_n) begin
        if (!rst_n) begin
            idx = 0; npul = 0; late_viol = 0; gate_viol = 0;
        end else begin
            if (sclk != last_sclk) begin
                if (cs_n || rd_n) gate_viol = gate_viol + 1;
                if (busy && bcnt >= HALF) late_viol = late_viol + 1;
                if (sclk == idle_hi && !cs_n && !rd_n) begin
                    idx = idx + 1; npul = npul + 1;
                end
            end
            if (cs_n || rd_n) begin
                idx = 0;
                if (!cs_n || !rd_n) npul = 0;
            end
            if (cs_n && rd_n && sclk == last_sclk) idx = 0;
        end
        if (!cs_n && prev_csn) npul = 0;
        last_sclk = sclk;
    end

    assign sdata = (!cs_n && !rd_n && idx < W) ? out_reg[W-1-idx] : 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ih, input int hp, input logic dur);
        go = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        idle_hi = ih; half_per = HP_W'(hp); rd_during = dur;
        repeat (3) @(negedge clk);
        chk(cs_n && rd_n, "R1 select idle", int'(cs_n & rd_n), 1);
        chk(sclk == ih, "R1 sclk idle level", int'(sclk), int'(ih));
        chk(!cnv_start && !word_vld, "R1 strobes low", int'(cnv_start | word_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_words(input int n);
        int t = 0;
        go = 1'b1;
        while (nw < n && t < 20000) begin
            @(negedge clk);
            t++;
        end
        go = 1'b0;
        chk(nw >= n, "R2 words delivered", nw, n);
        t = 0;
        while ((busy || !cs_n) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic common_checks(input string tag);
        chk(gate_viol == 0, {"R3 edges while deselected ", tag}, gate_viol, 0);
        chk(late_viol == 0, {"R11 late-half edges ", tag}, late_viol, 0);
        chk(fr_bad == 0 && nfr > 0, {"R4 pulses per frame ", tag}, fr_bad, 0);
        chk(bad_start == 0, {"R2 start while busy/open ", tag}, bad_start, 0);
        chk(vld2 == 0, {"R9 valid one cycle ", tag}, vld2, 0);
        chk(vcs_bad == 0, {"R9 released with valid ", tag}, vcs_bad, 0);
    endtask

    task automatic test_quiet;
        do_reset(1'b0, 1, 1'b0);
        repeat (200) @(negedge clk);
        chk(nstart == 0, "R2 no start without go", nstart, 0);
        chk(cs_n && sclk == 1'b0, "R1 still idle", int'(cs_n), 1);
    endtask

    task automatic test_after(input logic ih, input int hp, input string tag);
        int hpe = (hp == 0) ? 1 : hp;
        do_reset(ih, hp, 1'b0);
        wait_words(3);
        for (int i = 0; i < 3; i++) begin
            chk(wbuf[i] == hist[i], {"R6 R4 word ", tag}, int'(wbuf[i]), int'(hist[i]));
            chk(wbusy[i] == 1'b0, {"R6 read after busy ", tag}, int'(wbusy[i]), 0);
        end
        chk(minw == hpe && maxw == hpe, {"R10 phase width ", tag}, maxw, hpe);
        chk(sclk == ih, {"R5 rest level ", tag}, int'(sclk), int'(ih));
        common_checks(tag);
    endtask

    task automatic test_during_fit;
        do_reset(1'b0, 1, 1'b1);
        wait_words(3);
        for (int i = 0; i < 3; i++) begin
            chk(wbuf[i] == hist[i], "R7 previous result", int'(wbuf[i]), int'(hist[i]));
            chk(wbusy[i] == 1'b1, "R7 read within busy", int'(wbusy[i]), 1);
        end
        chk(minw == 1 && maxw == 1, "R10 phase width during", maxw, 1);
        common_checks("during-fit");
    endtask

    task automatic test_during_nofit;
        do_reset(1'b1, 2, 1'b1);
        wait_words(3);
        for (int i = 0; i < 3; i++) begin
            chk(wbuf[i] == hist[i], "R8 postponed result", int'(wbuf[i]), int'(hist[i]));
            chk(wbusy[i] == 1'b0, "R8 read after busy", int'(wbusy[i]), 0);
        end
        chk(minw == 2 && maxw == 2, "R10 phase width two", maxw, 2);
        common_checks("during-nofit");
    endtask

    initial begin
        test_quiet();
        test_after(1'b0, 3, "after-lowidle");
        test_after(1'b1, 1, "after-highidle");
        test_after(1'b0, 0, "after-hp0");
        test_during_fit();
        test_during_nofit();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule